// File: doc/BRIEF.md
# Request/Acknowledge Handshake Timing Monitor

This block passively observes a one-bit request line and a one-bit acknowledge line on a single clock. Each request transaction starts on a rising edge of the request line. The block then runs two checks on that transaction at the same time:

- A pulse-width check measures how long the request stays high.
- An acknowledge/release check first waits for an acknowledge edge. Once it sees one, it waits for the request line to drop.

Each check reports a violation through a one-cycle pulse and a sticky flag. The sticky flag holds until reset. A done pulse marks the cycle in which both checks have finished, whether they passed or failed.

The monitor never drives the handshake. It handles one transaction at a time. Anything seen before the first request rise after reset is outside its scope. It is meant to be dropped next to a handshake inside a larger design, so that timing violations are caught in hardware.

Top module: `hs_timing_mon`

## Requirements
- R1: While `rst` is high at a clock edge, all pulse outputs, sticky flags, counters and the stored previous samples of `req` and `ack` clear to 0, and both checks return to idle.
- R2: A transaction starts at an edge where `req` is sampled 1 after being sampled 0 at the previous edge, only if both checks are idle. Call that edge E0. A rise seen while either check is busy is ignored and is not held for later.
- R3: The acknowledge is accepted if `ack` is sampled rising (1 now, 0 at the previous edge) at one of the edges E1 to E10. If no rise is seen by E10, `noack_pulse_o` is high for the cycle after E10, and no release check is made for that transaction.
- R4: An `ack` that is already high before E0 does not count as an acknowledge. Neither does an `ack` that rises exactly at E0. Only a 0-to-1 change is accepted.
- R5: The request high count is the number of edges, starting at E0, at which `req` is sampled 1. The count is allowed to be 5, 6 or 7.
  - If `req` is first sampled 0 at edge Ek with k below 5, `width_pulse_o` is high for the cycle after Ek.
  - If `req` is still 1 at E7, `width_pulse_o` is high for the cycle after E7.
- R6: Let EA be the edge where the acknowledge rise was accepted. `req` must be sampled 0 at one of EA+1 to EA+10. If it is not, `norel_pulse_o` is high for the cycle after EA+10.
- R7: Each error pulse lasts one cycle. Its sticky flag (`noack_sticky_o`, `width_sticky_o`, `norel_sticky_o`) is set from the same edge onward and stays 1 until reset, across later transactions.
- R8: `done_o` is high for exactly one cycle. That cycle follows the edge at which the later of the two checks finishes.
- R9: The two checks are independent. A transaction may raise a width error together with an acknowledge or release error, each at its own edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Observed request line |
| ack | input | 1 | Observed acknowledge line |
| noack_pulse_o | output | 1 | One-cycle pulse: no acknowledge rise within its window |
| width_pulse_o | output | 1 | One-cycle pulse: request high count outside 5 to 7 |
| norel_pulse_o | output | 1 | One-cycle pulse: request not released after acknowledge |
| noack_sticky_o | output | 1 | Sticky flag for the missing-acknowledge error |
| width_sticky_o | output | 1 | Sticky flag for the width error |
| norel_sticky_o | output | 1 | Sticky flag for the release error |
| done_o | output | 1 | One-cycle pulse when both checks of a transaction are over |

## Verification
The sweep crosses every request high count from 1 to 12 with every acknowledge edge position from none through E0 up to E12. A separate case holds acknowledge high from before the start. Together these separate the boundary counts 4/5, 7/8 and 10/11 of all three windows, and they tell an edge-detected acknowledge from a level-detected one. The sweep also covers the release window both when the request falls before the acknowledge and when it falls long after it. A second scenario makes the request rise again while the acknowledge check is still busy, then runs a clean transaction without reset. This shows that the late rise is dropped and that the sticky flags survive.

// File: rtl/hs_timing_mon.sv
module hs_timing_mon #(
  parameter int ACK_WIN   = 10,
  parameter int WIDTH_MIN = 5,
  parameter int WIDTH_MAX = 7,
  parameter int REL_WIN   = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic ack,
  output logic noack_pulse_o,
  output logic width_pulse_o,
  output logic norel_pulse_o,
  output logic noack_sticky_o,
  output logic width_sticky_o,
  output logic norel_sticky_o,
  output logic done_o
);

  localparam int AR_MAX = (ACK_WIN > REL_WIN) ? ACK_WIN : REL_WIN;
  localparam int ACW    = $clog2(AR_MAX + 1);
  localparam int WCW    = $clog2(WIDTH_MAX + 1);

  typedef enum logic [1:0] {AR_IDLE, AR_WAIT, AR_HOLD} ar_state_t;

  logic            req_q, ack_q;
  logic            pw_busy;
  logic [WCW-1:0]  pw_cnt;
  ar_state_t       ar_st;
  logic [ACW-1:0]  ar_cnt;

  logic req_rise, ack_rise, start;
  logic pw_fin, pw_bad;
  logic ar_got, ar_noack, ar_rel, ar_norel, ar_fin;
  logic pw_busy_n, ar_busy_n, busy_now;

  assign req_rise = req & ~req_q;
  assign ack_rise = ack & ~ack_q;
  assign start    = req_rise & ~pw_busy & (ar_st == AR_IDLE);

  assign pw_fin = pw_busy & (~req | (pw_cnt == WCW'(WIDTH_MAX)));
  assign pw_bad = pw_busy & (req ? (pw_cnt == WCW'(WIDTH_MAX))
                                 : (pw_cnt < WCW'(WIDTH_MIN)));

  assign ar_got   = (ar_st == AR_WAIT) & ack_rise;
  assign ar_noack = (ar_st == AR_WAIT) & ~ack_rise & (ar_cnt == ACW'(ACK_WIN));
  assign ar_rel   = (ar_st == AR_HOLD) & ~req;
  assign ar_norel = (ar_st == AR_HOLD) & req & (ar_cnt == ACW'(REL_WIN));
  assign ar_fin   = ar_noack | ar_rel | ar_norel;

  assign busy_now  = pw_busy | (ar_st != AR_IDLE);
  assign pw_busy_n = start | (pw_busy & ~pw_fin);
  assign ar_busy_n = start | ((ar_st != AR_IDLE) & ~ar_fin);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      req_q <= req;
      ack_q <= ack;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pw_busy <= 1'b0;
      pw_cnt  <= '0;
    end else if (start) begin
      pw_busy <= 1'b1;
      pw_cnt  <= WCW'(1);
    end else if (pw_fin) begin
      pw_busy <= 1'b0;
      pw_cnt  <= '0;
    end else if (pw_busy) begin
      pw_cnt  <= pw_cnt + WCW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ar_st  <= AR_IDLE;
      ar_cnt <= '0;
    end else if (start) begin
      ar_st  <= AR_WAIT;
      ar_cnt <= ACW'(1);
    end else if (ar_got) begin
      ar_st  <= AR_HOLD;
      ar_cnt <= ACW'(1);
    end else if (ar_fin) begin
      ar_st  <= AR_IDLE;
      ar_cnt <= '0;
    end else if (ar_st != AR_IDLE) begin
      ar_cnt <= ar_cnt + ACW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      noack_pulse_o  <= 1'b0;
      width_pulse_o  <= 1'b0;
      norel_pulse_o  <= 1'b0;
      noack_sticky_o <= 1'b0;
      width_sticky_o <= 1'b0;
      norel_sticky_o <= 1'b0;
      done_o         <= 1'b0;
    end else begin
      noack_pulse_o  <= ar_noack;
      width_pulse_o  <= pw_bad;
      norel_pulse_o  <= ar_norel;
      noack_sticky_o <= noack_sticky_o | ar_noack;
      width_sticky_o <= width_sticky_o | pw_bad;
      norel_sticky_o <= norel_sticky_o | ar_norel;
      done_o         <= busy_now & ~pw_busy_n & ~ar_busy_n;
    end
  end

endmodule

module hs_timing_mon_chk (
  input logic clk,
  input logic rst,
  input logic noack_pulse_o,
  input logic width_pulse_o,
  input logic norel_pulse_o,
  input logic noack_sticky_o,
  input logic width_sticky_o,
  input logic norel_sticky_o,
  input logic done_o
);

  AST_NOACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    noack_pulse_o |=> !noack_pulse_o); // R7
  AST_WIDTH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    width_pulse_o |=> !width_pulse_o); // R7
  AST_NOREL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    norel_pulse_o |=> !norel_pulse_o); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8
  AST_NOACK_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    noack_sticky_o |=> noack_sticky_o); // R7
  AST_WIDTH_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    width_sticky_o |=> width_sticky_o); // R7
  AST_NOREL_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    norel_sticky_o |=> norel_sticky_o); // R7
  AST_WIDTH_PULSE_STICKY: assert property (@(posedge clk) disable iff (rst)
    width_pulse_o |-> width_sticky_o); // R7
  AST_ACK_SIDE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(noack_pulse_o && norel_pulse_o)); // R6

endmodule

bind hs_timing_mon hs_timing_mon_chk chk_i (
  .clk(clk), .rst(rst),
  .noack_pulse_o(noack_pulse_o), .width_pulse_o(width_pulse_o),
  .norel_pulse_o(norel_pulse_o), .noack_sticky_o(noack_sticky_o),
  .width_sticky_o(width_sticky_o), .norel_sticky_o(norel_sticky_o),
  .done_o(done_o)
);

// File: tb/hs_timing_mon_tb.sv
module hs_timing_mon_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic ack = 1'b0;
  logic noack_p, width_p, norel_p, noack_s, width_s, norel_s, done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hs_timing_mon dut_i (
    .clk(clk), .rst(rst), .req(req), .ack(ack),
    .noack_pulse_o(noack_p), .width_pulse_o(width_p), .norel_pulse_o(norel_p),
    .noack_sticky_o(noack_s), .width_sticky_o(width_s), .norel_sticky_o(norel_s),
    .done_o(done)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req = 1'b0; ack = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // One transaction; req high for pw edges from E0, ack rise at edge k (k<0: none)
  task automatic run_tx(int pw, int k, bit stuck, bit pw0, bit pn0, bit pr0);
    int  wedge, aredge, dedge, r;
    bit  werr, naerr, nrerr, ackok, both;
    string tna;
    wedge  = (pw <= 7) ? pw : 7;
    werr   = (pw < 5) || (pw > 7);
    ackok  = !stuck && (k >= 1) && (k <= 10);
    naerr  = !ackok;
    nrerr  = 1'b0;
    aredge = 10;
    if (ackok) begin
      r = (pw > k + 1) ? pw : k + 1;
      if (r - k <= 10) aredge = r;
      else begin aredge = k + 10; nrerr = 1'b1; end
    end
    dedge = (wedge > aredge) ? wedge : aredge;
    both  = werr && (naerr || nrerr);
    tna   = (stuck || k == 0) ? "R4 noack" : "R3 noack";
    req = 1'b0; ack = stuck;
    @(negedge clk);
    for (int t = 0; t < 28; t++) begin
      req = (t < pw);
      ack = stuck ? 1'b1 : (k >= 0 && (t == k || t == k + 1));
      @(negedge clk);
      chk(both ? "R9 width" : "R5 width", width_p, werr && t == wedge);
      chk(tna, noack_p, naerr && t == 10);
      chk(both ? "R9 norel" : "R6 norel", norel_p, nrerr && t == aredge);
      chk("R8 done", done, t == dedge);
      chk("R7 width sticky", width_s, pw0 || (werr && t >= wedge));
      chk("R7 noack sticky", noack_s, pn0 || (naerr && t >= 10));
      chk("R7 norel sticky", norel_s, pr0 || (nrerr && t >= aredge));
    end
  endtask

  task automatic check_cleared();
    chk("R1 noack pulse", noack_p, 1'b0);
    chk("R1 width pulse", width_p, 1'b0);
    chk("R1 norel pulse", norel_p, 1'b0);
    chk("R1 noack sticky", noack_s, 1'b0);
    chk("R1 width sticky", width_s, 1'b0);
    chk("R1 norel sticky", norel_s, 1'b0);
    chk("R1 done", done, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check_cleared();

    // Sweep of request widths against acknowledge positions
    for (int pw = 1; pw <= 12; pw++) begin
      for (int k = -1; k <= 12; k++) begin
        do_reset();
        run_tx(pw, k, 1'b0, 1'b0, 1'b0, 1'b0);
      end
      do_reset();
      run_tx(pw, 3, 1'b1, 1'b0, 1'b0, 1'b0);
    end

    // R2: second rise while the acknowledge check is still busy
    do_reset();
    req = 1'b0; ack = 1'b0;
    @(negedge clk);
    for (int t = 0; t <= 30; t++) begin
      req = (t < 2) || (t >= 4 && t < 13);
      ack = 1'b0;
      @(negedge clk);
      chk("R2 width", width_p, t == 2);
      chk("R2 noack", noack_p, t == 10);
      chk("R2 norel", norel_p, 1'b0);
      chk("R2 done", done, t == 10);
    end

    // R7: clean transaction without reset keeps earlier sticky flags
    run_tx(6, 3, 1'b0, 1'b1, 1'b1, 1'b0);

    do_reset();
    check_cleared();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule